// File: doc/BRIEF.md
# Framed Synchronous Serial Receiver

This block is the receive half of a synchronous serial port that takes 16-bit words from an external controller. The port is the clock and sync master: it divides the system clock down to a bit clock with a programmable divisor, and it drives an active-high frame sync that the controller uses to start sending. One frame sync pulse opens the transfer. From then on words arrive back to back, with no further sync, for as long as the port stays enabled.

Each completed word is written to a small receive buffer of GROUP entries, in arrival order, and wraps around. A group flag changes state each time the last buffer entry is written. Because the flag toggles rather than pulses, a slow poller that compares the flag with its last known value never misses a completed group. Dropping the enable input stops the bit clock, clears the bit and word positions and re-arms the port, so the next enable sends a new frame sync. Buffer contents and the flag survive this.

Top module: `frame_serial_rx`

## Requirements
- R1: While enabled, the bit clock output has a period of 2*(div+1) system clock cycles and stays high for div+1 cycles and low for div+1 cycles. A divisor of 0x1F is supported.
- R2: After each enable, the frame sync output goes high exactly once, at a rising bit clock edge. It stays high for one bit clock period, 2*(div+1) system cycles.
- R3: Serial data is sampled at the rising bit clock edges. The first data bit is the one sampled at the rising edge where frame sync goes low, and each word is assembled most significant bit first.
- R4: After the first word, every further 16 rising edges form the next word. There are no idle bits between words and no further frame sync.
- R5: The k-th word after an enable (counting from 0) is stored in buffer entry k mod GROUP, and can be read combinationally by placing the entry index on the read address.
- R6: The group flag inverts each time buffer entry GROUP-1 is written, and holds its value otherwise, including after a partial group.
- R7: While enable is low, the bit clock and frame sync outputs are low. A later enable starts over: a new frame sync, the first word again at entry 0, and the buffer contents and group flag unchanged.
- R8: After reset, the bit clock, frame sync and group flag are 0, and every buffer entry reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| enable | input | 1 | Runs the port; low re-arms it |
| clk_div | input | DIV_W | Bit clock divisor div |
| sdi | input | 1 | Serial data from the controller |
| sclk_o | output | 1 | Generated bit clock |
| fsync_o | output | 1 | Generated frame sync, active high |
| grp_flag_o | output | 1 | Toggles once per completed group |
| rd_addr | input | PTR_W | Buffer read index |
| rd_data | output | WORD_W | Buffer entry at rd_addr |

## Verification
The bench plays the external controller. It starts a word on each falling bit clock edge once it sees frame sync, using divisors from 0 up to 0x1F. This exposes a divider that is off by one in either half-period, and a receiver that takes the first bit one edge early or late, which would leave every stored word shifted by one bit.

Stream lengths are random, up to two groups. They catch a write pointer that fails to wrap, and a flag that toggles on every word or on a partial group. Directed words such as 0x8001 expose reversed bit order.

An enable drop in the middle of a word checks that the partial word is thrown away, that writing starts again at entry 0, and that a second frame sync appears. A design that skipped the re-arm would store misaligned words from the old bit position.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

   // receiver framing phases
   typedef enum logic [1:0] {
      RX_ARM  = 2'd0,   // waiting to issue the opening frame sync
      RX_SYNC = 2'd1,   // frame sync is on the line for one bit period
      RX_RUN  = 2'd2    // continuous unframed words
   } rx_state_e;

   // width of a counter able to hold 0 .. n-1 (at least one bit)
   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/fsr_bitclk.sv
module fsr_bitclk #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic [DIV_W-1:0] div_i,
   output logic             sclk_o,
   output logic             rise_o
);

   logic [DIV_W-1:0] cnt_q;
   logic             sclk_q;
   logic             term_cnt;

   generate
      if (DIV_W < 1) begin : g_bad_div_w
         $error("fsr_bitclk: DIV_W must be at least 1");
      end
   endgenerate

   // a half period ends when the counter reaches the divisor; the >= keeps
   // the clock alive if the divisor is lowered under a running count
   assign term_cnt = (cnt_q >= div_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         sclk_q <= 1'b0;
      end else if (!run_i) begin
         cnt_q  <= '0;
         sclk_q <= 1'b0;
      end else if (term_cnt) begin
         cnt_q  <= '0;
         sclk_q <= ~sclk_q;
      end else begin
         cnt_q  <= cnt_q + 1'b1;
      end
   end

   // high during the system cycle whose closing edge raises the bit clock
   assign rise_o = run_i && term_cnt && !sclk_q;
   assign sclk_o = sclk_q;

   // R1
   hold_mid_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && (cnt_q < div_i)) |=> $stable(sclk_q));

   // R7
   idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run_i |=> !sclk_q);

endmodule

// File: rtl/fsr_deser.sv
module fsr_deser
   import fsr_pkg::*;
#(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run_i,
   input  logic              rise_i,
   input  logic              sdi_i,
   output logic              fsync_o,
   output logic [WORD_W-1:0] word_o,
   output logic              word_vld_o
);

   localparam int CNT_W = idx_width(WORD_W);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

   rx_state_e         state_q;
   logic [CNT_W-1:0]  bitcnt_q;
   logic [WORD_W-1:0] shreg_q;
   logic [WORD_W-1:0] word_q;
   logic              vld_q;
   logic              fsync_q;
   logic [WORD_W-1:0] shifted;

   generate
      if (WORD_W < 2) begin : g_bad_word_w
         $error("fsr_deser: WORD_W must be at least 2");
      end
   endgenerate

   // MSB first: older bits move up, the new bit enters at bit 0
   assign shifted = {shreg_q[WORD_W-2:0], sdi_i};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= RX_ARM;
         bitcnt_q <= '0;
         shreg_q  <= '0;
         word_q   <= '0;
         vld_q    <= 1'b0;
         fsync_q  <= 1'b0;
      end else if (!run_i) begin
         state_q  <= RX_ARM;
         bitcnt_q <= '0;
         vld_q    <= 1'b0;
         fsync_q  <= 1'b0;
      end else begin
         vld_q <= 1'b0;
         if (rise_i) begin
            unique case (state_q)
               RX_ARM: begin
                  fsync_q <= 1'b1;
                  state_q <= RX_SYNC;
               end
               RX_SYNC, RX_RUN: begin
                  fsync_q <= 1'b0;
                  state_q <= RX_RUN;
                  shreg_q <= shifted;
                  if (bitcnt_q == LAST_BIT) begin
                     bitcnt_q <= '0;
                     word_q   <= shifted;
                     vld_q    <= 1'b1;
                  end else begin
                     bitcnt_q <= bitcnt_q + 1'b1;
                  end
               end
               default: begin
                  state_q <= RX_ARM;
                  fsync_q <= 1'b0;
               end
            endcase
         end
      end
   end

   assign fsync_o    = fsync_q;
   assign word_o     = word_q;
   assign word_vld_o = vld_q;

   // R2
   sync_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fsync_q) |-> ($past(state_q) == RX_ARM));

   // R4
   no_sync_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == RX_RUN) |-> !fsync_q);

   // R4
   word_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vld_q |-> ((bitcnt_q == '0) && (state_q == RX_RUN)));

endmodule

// File: rtl/fsr_rxbuf.sv
module fsr_rxbuf
   import fsr_pkg::*;
#(
   parameter int WORD_W = 16,
   parameter int DEPTH  = 8,
   localparam int PTR_W = idx_width(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run_i,
   input  logic              wr_i,
   input  logic [WORD_W-1:0] wdata_i,
   input  logic [PTR_W-1:0]  rd_addr_i,
   output logic [WORD_W-1:0] rd_data_o,
   output logic              flag_o
);

   localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
   localparam bit POW2 = (DEPTH == (1 << PTR_W));

   logic [PTR_W-1:0]  ptr_q;
   logic [PTR_W-1:0]  ptr_nxt;
   logic              flag_q;
   logic [WORD_W-1:0] ent_data [DEPTH];

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("fsr_rxbuf: DEPTH must be at least 2");
      end

      // pointer wrap: free-running for power-of-two depths, compared otherwise
      if (POW2) begin : g_wrap_free
         assign ptr_nxt = ptr_q + 1'b1;
      end else begin : g_wrap_cmp
         assign ptr_nxt = (ptr_q == LAST_PTR) ? '0 : ptr_q + 1'b1;
      end

      // one register per entry, each with its own write decode
      for (genvar e = 0; e < DEPTH; e++) begin : g_ent
         logic [WORD_W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               q <= '0;
            end else if (wr_i && (ptr_q == PTR_W'(e))) begin
               q <= wdata_i;
            end
         end
         assign ent_data[e] = q;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q  <= '0;
         flag_q <= 1'b0;
      end else begin
         if (!run_i) begin
            ptr_q <= '0;
         end else if (wr_i) begin
            ptr_q <= ptr_nxt;
         end
         if (run_i && wr_i && (ptr_q == LAST_PTR)) begin
            flag_q <= ~flag_q;
         end
      end
   end

   assign rd_data_o = ({1'b0, rd_addr_i} < (PTR_W + 1)'(DEPTH)) ? ent_data[rd_addr_i] : '0;
   assign flag_o    = flag_q;

   // R5
   ptr_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, ptr_q} < (PTR_W + 1)'(DEPTH)));

   // R6
   flag_on_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(flag_q) |-> ($past(wr_i) && ($past(ptr_q) == LAST_PTR)));

   // R7
   rearm_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run_i |=> (ptr_q == '0));

endmodule

// File: rtl/frame_serial_rx.sv
module frame_serial_rx
   import fsr_pkg::*;
#(
   parameter int WORD_W = 16,
   parameter int DIV_W  = 8,
   parameter int GROUP  = 8,
   localparam int PTR_W = idx_width(GROUP)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic [DIV_W-1:0]  clk_div,
   input  logic              sdi,
   output logic              sclk_o,
   output logic              fsync_o,
   output logic              grp_flag_o,
   input  logic [PTR_W-1:0]  rd_addr,
   output logic [WORD_W-1:0] rd_data
);

   logic              rise;
   logic [WORD_W-1:0] word;
   logic              word_vld;

   generate
      if (WORD_W != 16) begin : g_word_note
         $info("frame_serial_rx: built with a non-16-bit word");
      end
   endgenerate

   fsr_bitclk #(
      .DIV_W (DIV_W)
   ) u_bitclk (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (enable),
      .div_i  (clk_div),
      .sclk_o (sclk_o),
      .rise_o (rise)
   );

   fsr_deser #(
      .WORD_W (WORD_W)
   ) u_deser (
      .clk        (clk),
      .rst_n      (rst_n),
      .run_i      (enable),
      .rise_i     (rise),
      .sdi_i      (sdi),
      .fsync_o    (fsync_o),
      .word_o     (word),
      .word_vld_o (word_vld)
   );

   fsr_rxbuf #(
      .WORD_W (WORD_W),
      .DEPTH  (GROUP)
   ) u_rxbuf (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_i     (enable),
      .wr_i      (word_vld),
      .wdata_i   (word),
      .rd_addr_i (rd_addr),
      .rd_data_o (rd_data),
      .flag_o    (grp_flag_o)
   );

   // R2
   sync_with_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fsync_o) |-> $rose(sclk_o));

endmodule

// File: tb/frame_serial_rx_tb_top.sv
module frame_serial_rx_tb_top;

   localparam int WORD_W = 16;
   localparam int DIV_W  = 8;
   localparam int GROUP  = 8;
   localparam int PTR_W  = 3;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              enable = 1'b0;
   logic [DIV_W-1:0]  clk_div = '0;
   logic              sdi = 1'b0;
   logic [PTR_W-1:0]  rd_addr = '0;
   logic              sclk_o, fsync_o, grp_flag_o;
   logic [WORD_W-1:0] rd_data;

   always #4 clk = ~clk;   // 125 MHz

   frame_serial_rx #(
      .WORD_W (WORD_W),
      .DIV_W  (DIV_W),
      .GROUP  (GROUP)
   ) dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .enable     (enable),
      .clk_div    (clk_div),
      .sdi        (sdi),
      .sclk_o     (sclk_o),
      .fsync_o    (fsync_o),
      .grp_flag_o (grp_flag_o),
      .rd_addr    (rd_addr),
      .rd_data    (rd_data)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   // bench reference model
   logic [15:0] exp_mem [GROUP];
   logic        exp_flag = 1'b0;
   int          exp_wp = 0;
   logic [15:0] words [64];
   int          cur_div = 0;
   int          fs_snap = 0;

   // frame sync monitor (observes outputs only)
   int   fs_rises = 0;
   int   fs_width = 0;
   int   fs_run   = 0;
   logic fs_prev  = 1'b0;
   always @(negedge clk) begin
      fs_prev <= fsync_o;
      if (fsync_o && !fs_prev) fs_rises <= fs_rises + 1;
      if (fsync_o) begin
         fs_run <= fs_run + 1;
      end else if (fs_run != 0) begin
         fs_width <= fs_run;
         fs_run   <= 0;
      end
   end

   task automatic check_eq(input string req, input string what, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic int model_next(input int wp);
      return (wp + 1) % GROUP;
   endfunction

   task automatic start_run(input int d);
      enable = 1'b0;
      @(negedge clk);
      clk_div = DIV_W'(d);
      cur_div = d;
      fs_snap = fs_rises;
      exp_wp  = 0;
      enable  = 1'b1;
   endtask

   // act as the controller: launch a bit on each falling bit clock edge
   task automatic stream(input int n);
      logic prev;
      bit   started;
      int   b;
      prev = sclk_o;
      started = 1'b0;
      b = 0;
      while (b < n * 16) begin
         @(negedge clk);
         if (prev && !sclk_o && (started || fsync_o)) begin
            started = 1'b1;
            sdi = words[b / 16][15 - (b % 16)];
            b++;
            if ((b % 16) == 0) begin
               exp_mem[exp_wp] = words[(b / 16) - 1];
               exp_wp = model_next(exp_wp);
               if (exp_wp == 0) exp_flag = ~exp_flag;
            end
         end
         prev = sclk_o;
      end
      do @(negedge clk); while (!sclk_o);
      @(negedge clk);
      @(negedge clk);
   endtask

   task automatic wait_rises(input int k);
      for (int i = 0; i < k; i++) begin
         do @(negedge clk); while (sclk_o);
         do @(negedge clk); while (!sclk_o);
      end
   endtask

   task automatic check_buffer(input string req);
      for (int a = 0; a < GROUP; a++) begin
         rd_addr = PTR_W'(a);
         #1;
         check_eq(req, $sformatf("entry %0d", a), rd_data, exp_mem[a]);
      end
      check_eq("R6", "group flag", grp_flag_o, exp_flag);
   endtask

   task automatic measure_clock(input int d);
      int hi, lo;
      start_run(d);
      do @(negedge clk); while (!sclk_o);
      for (int p = 0; p < 2; p++) begin
         hi = 0;
         lo = 0;
         while (sclk_o) begin hi++; @(negedge clk); end
         while (!sclk_o) begin lo++; @(negedge clk); end
         check_eq("R1", $sformatf("high cycles div=%0d", d), hi, d + 1);
         check_eq("R1", $sformatf("low cycles div=%0d", d), lo, d + 1);
      end
      enable = 1'b0;
      @(negedge clk);
      @(negedge clk);
      check_eq("R7", "bit clock low when disabled", sclk_o, 0);
      check_eq("R7", "frame sync low when disabled", fsync_o, 0);
   endtask

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_bad++;
         n_chk++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      int seed;
      int n;
      int d;
      seed = $urandom(32'h5EED_0091);
      for (int i = 0; i < GROUP; i++) exp_mem[i] = '0;

      repeat (4) @(negedge clk);
      // R8 reset state, held in reset
      check_eq("R8", "bit clock in reset", sclk_o, 0);
      check_eq("R8", "frame sync in reset", fsync_o, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check_eq("R8", "group flag after reset", grp_flag_o, 0);
      check_buffer("R8");

      // R1 clock division, including 0x1F
      measure_clock(32'h1F);
      measure_clock(0);
      measure_clock(3);

      // directed stream: R3 bit order, R2 single sync, R4 back to back
      words[0] = 16'h8001; words[1] = 16'h0000; words[2] = 16'hFFFF; words[3] = 16'hA5C3;
      words[4] = 16'h0001; words[5] = 16'h8000; words[6] = 16'h7FFE; words[7] = 16'h1234;
      start_run(2);
      stream(GROUP);
      check_eq("R2", "frame sync count", fs_rises - fs_snap, 1);
      check_eq("R2", "frame sync width", fs_width, 2 * (cur_div + 1));
      enable = 1'b0;
      @(negedge clk);
      rd_addr = '0;
      #1;
      check_eq("R3", "first word MSB first", rd_data, 16'h8001);
      check_buffer("R4");

      // random streams of up to two groups
      for (int it = 0; it < 6; it++) begin
         d = $urandom % 4;
         n = ($urandom % (2 * GROUP)) + 1;
         for (int w = 0; w < n; w++) words[w] = 16'($urandom);
         start_run(d);
         stream(n);
         check_eq("R2", "frame sync count per enable", fs_rises - fs_snap, 1);
         check_eq("R2", "frame sync width", fs_width, 2 * (d + 1));
         enable = 1'b0;
         @(negedge clk);
         check_buffer("R5");
      end

      // R7 abort mid-word, then restart
      for (int w = 0; w < 2; w++) words[w] = 16'($urandom);
      start_run(1);
      stream(2);
      sdi = 1'b1;
      wait_rises(6);
      enable = 1'b0;
      repeat (3) @(negedge clk);
      check_eq("R7", "bit clock low in abort", sclk_o, 0);
      check_eq("R7", "frame sync low in abort", fsync_o, 0);
      check_buffer("R7");
      for (int w = 0; w < 3; w++) words[w] = 16'($urandom);
      start_run(1);
      stream(3);
      check_eq("R7", "new frame sync after re-enable", fs_rises - fs_snap, 1);
      enable = 1'b0;
      @(negedge clk);
      check_buffer("R7");

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule